// File: doc/BRIEF.md
# Local Interrupt Priority and Acceptance Core

This block is the arbitration heart of a per-processor interrupt controller. It keeps three 256-bit vectors: requests waiting for service, vectors currently in service, and the trigger mode of each vector. External logic posts requests through a set port that carries a vector number and a trigger mode. Software sets the task priority and a spurious/enable register. The processor takes an interrupt with an acknowledge strobe and retires it with an end-of-interrupt strobe.

Priority is judged per class of 16 vectors, which is the upper nibble of the vector number. The processor priority is the larger of two values: the task priority, and the class of the highest vector in service. A request raises the pending line only if its class is above that priority. On acknowledge the core returns one of two things: the highest request, or the spurious vector when that request sits at or below the task priority. On end-of-interrupt it reports the retired vector and that vector's trigger mode.

All outputs are combinational views of the registered state and of the strobes in the current cycle. Every state change takes effect at the next rising clock edge.

Top module: `lapic_prio_core`

## Requirements
- R1: The vector chosen from a 256-bit set is the highest-numbered set bit. A non-spurious acknowledge returns the highest set request bit.
- R2: Vector class is bits [7:4]. The output `ppr_out` equals the task priority when the task priority's class is greater than or equal to the class of the highest in-service vector. Otherwise it equals that class followed by four zero bits. With nothing in service the in-service class counts as 0.
- R3: `irq_pending` is 1 only under all three conditions. The enable bit (spurious register bit 8) is 1. At least one request bit is set. Either `ppr_out` is 0, or the highest request's class is strictly greater than `ppr_out[7:4]`.
- R4: A request with `req_level`=1 records level mode for that vector; `req_level`=0 records edge mode. The recorded mode is reported on `eoi_level` when that vector is retired.
- R5: An acknowledge is spurious when the task priority is nonzero and the highest request vector is less than or equal to it. It then asserts `ack_spurious`, returns spurious register bits [7:0] on `ack_vector`, and leaves the request and in-service vectors unchanged.
- R6: A non-spurious valid acknowledge clears the highest request bit and sets the same in-service bit at the next edge.
- R7: End-of-interrupt clears the highest set in-service bit and reports it on `eoi_vector` with `eoi_done`=1. With no bit in service, `eoi_done` is 0 and nothing changes.
- R8: After reset the spurious register holds 0x0FF, so the core is disabled. The task priority is 0 and all three vectors are cleared, which gives `irq_pending`=0 and `ppr_out`=0.
- R9: If the core is disabled or no request bit is set, an acknowledge gives `ack_valid`=0 and changes no state.
- R10: A spurious register write stores all 9 bits of `svr_wdata`. A task priority write stores all 8 bits of `tpr_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Post a request this cycle |
| req_vector | input | 8 | Vector of the posted request |
| req_level | input | 1 | 1 = level mode, 0 = edge mode |
| tpr_wr | input | 1 | Write task priority |
| tpr_wdata | input | 8 | New task priority |
| svr_wr | input | 1 | Write spurious/enable register |
| svr_wdata | input | 9 | Bit 8 enable, bits [7:0] spurious vector |
| ack_strobe | input | 1 | Processor acknowledge |
| eoi_strobe | input | 1 | End of interrupt |
| irq_pending | output | 1 | Interrupt should be signalled to the processor |
| ack_valid | output | 1 | Acknowledge returned a vector |
| ack_spurious | output | 1 | Returned vector is the spurious one |
| ack_vector | output | 8 | Vector returned on acknowledge |
| eoi_done | output | 1 | End-of-interrupt retired a vector |
| eoi_vector | output | 8 | Retired vector |
| eoi_level | output | 1 | Trigger mode recorded for the retired vector |
| ppr_out | output | 8 | Processor priority |

## Verification
The properties expect a known 0 or 1 on every strobe. Several strobes in one cycle are legal: a request set overrides an acknowledge clear, and an acknowledge set overrides an end-of-interrupt clear on the same vector. The properties that look at state holding still exclude cycles in which a request or end-of-interrupt is also active. The stimulus applies exactly one operation per cycle, so every cycle lands in a case the properties cover. Random vectors span the full 0 to 255 range. Task priorities land in many classes, and the enable bit is dropped now and then.

// File: rtl/lapic_prio_pkg.sv
package lapic_prio_pkg;
    parameter int LPC_NUM_VEC    = 256;
    parameter int LPC_CLASS_SIZE = 16;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;
endpackage

// File: rtl/lapic_prio_find.sv
module lapic_prio_find #(
    parameter int WIDTH = lapic_prio_pkg::LPC_NUM_VEC,
    parameter int GROUP = lapic_prio_pkg::LPC_CLASS_SIZE,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    localparam int NGRP   = WIDTH / GROUP;
    localparam int GIDX_W = $clog2(GROUP);
    localparam int SEL_W  = $clog2(NGRP);

    logic [NGRP-1:0]        grp_any;
    logic [NGRP*GIDX_W-1:0] lo_flat;
    logic [SEL_W-1:0]       sel;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GIDX_W-1:0] lo;
        always_comb begin
            lo = '0;
            for (int b = 0; b < GROUP; b++) begin
                if (vec[g*GROUP+b]) lo = GIDX_W'(b);
            end
        end
        assign grp_any[g]                     = |vec[g*GROUP +: GROUP];
        assign lo_flat[g*GIDX_W +: GIDX_W]    = lo;
    end

    always_comb begin
        sel = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_any[g]) sel = SEL_W'(g);
        end
    end

    assign found = |grp_any;
    assign idx   = {sel, lo_flat[sel*GIDX_W +: GIDX_W]};
endmodule

// File: rtl/lapic_prio_eval.sv
module lapic_prio_eval #(
    parameter int VEC_W = 8,
    parameter int PRI_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             svr_en,
    input  logic [VEC_W-1:0] svr_vec,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_idx,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_idx,
    output logic [VEC_W-1:0] ppr,
    output logic             pending,
    output logic             ack_ok,
    output logic             ack_spur,
    output logic [VEC_W-1:0] ack_vec
);
    localparam int CLS_LSB = VEC_W - PRI_W;

    logic [PRI_W-1:0] isr_cls;
    logic [PRI_W-1:0] tpr_cls;
    logic [PRI_W-1:0] irr_cls;

    always_comb begin
        isr_cls = isr_found ? isr_idx[VEC_W-1:CLS_LSB] : '0;
        tpr_cls = tpr[VEC_W-1:CLS_LSB];
        irr_cls = irr_idx[VEC_W-1:CLS_LSB];
        if (tpr_cls >= isr_cls) ppr = tpr;
        else                    ppr = {isr_cls, {CLS_LSB{1'b0}}};
        pending  = svr_en && irr_found &&
                   ((ppr == '0) || (irr_cls > ppr[VEC_W-1:CLS_LSB]));
        ack_ok   = svr_en && irr_found;
        ack_spur = (tpr != '0) && (irr_idx <= tpr);
        ack_vec  = ack_spur ? svr_vec : irr_idx;
    end
endmodule

// File: rtl/lapic_prio_core.sv
module lapic_prio_core #(
    parameter int NUM_VEC    = lapic_prio_pkg::LPC_NUM_VEC,
    parameter int CLASS_SIZE = lapic_prio_pkg::LPC_CLASS_SIZE,
    localparam int VEC_W = $clog2(NUM_VEC),
    localparam int SVR_W = VEC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic             req_level,
    input  logic             tpr_wr,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             svr_wr,
    input  logic [SVR_W-1:0] svr_wdata,
    input  logic             ack_strobe,
    input  logic             eoi_strobe,
    output logic             irq_pending,
    output logic             ack_valid,
    output logic             ack_spurious,
    output logic [VEC_W-1:0] ack_vector,
    output logic             eoi_done,
    output logic [VEC_W-1:0] eoi_vector,
    output logic             eoi_level,
    output logic [VEC_W-1:0] ppr_out
);
    import lapic_prio_pkg::*;

    localparam int PRI_W = VEC_W - $clog2(CLASS_SIZE);
    localparam logic [SVR_W-1:0] SVR_RST = {1'b0, {VEC_W{1'b1}}};

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic [VEC_W-1:0]   tpr;
        logic [SVR_W-1:0]   svr;
    } state_t;

    state_t state_d, state_q;

    logic             irr_found, isr_found;
    logic [VEC_W-1:0] irr_idx, isr_idx;
    logic             ack_ok, ack_spur, ack_take;
    logic [VEC_W-1:0] ack_vec;

    lapic_prio_find #(.WIDTH(NUM_VEC), .GROUP(CLASS_SIZE)) u_find_irr (
        .vec(state_q.irr), .found(irr_found), .idx(irr_idx)
    );

    lapic_prio_find #(.WIDTH(NUM_VEC), .GROUP(CLASS_SIZE)) u_find_isr (
        .vec(state_q.isr), .found(isr_found), .idx(isr_idx)
    );

    lapic_prio_eval #(.VEC_W(VEC_W), .PRI_W(PRI_W)) u_eval (
        .tpr(state_q.tpr),
        .svr_en(state_q.svr[VEC_W]),
        .svr_vec(state_q.svr[VEC_W-1:0]),
        .irr_found(irr_found),
        .irr_idx(irr_idx),
        .isr_found(isr_found),
        .isr_idx(isr_idx),
        .ppr(ppr_out),
        .pending(irq_pending),
        .ack_ok(ack_ok),
        .ack_spur(ack_spur),
        .ack_vec(ack_vec)
    );

    assign ack_valid    = ack_strobe && ack_ok;
    assign ack_spurious = ack_valid && ack_spur;
    assign ack_vector   = ack_vec;
    assign ack_take     = ack_valid && !ack_spur;
    assign eoi_done     = eoi_strobe && isr_found;
    assign eoi_vector   = isr_idx;
    assign eoi_level    = state_q.tmr[isr_idx];

    always_comb begin
        state_d = state_q;
        if (tpr_wr) state_d.tpr = tpr_wdata;
        if (svr_wr) state_d.svr = svr_wdata;
        if (eoi_done) state_d.isr[isr_idx] = 1'b0;
        if (ack_take) begin
            state_d.irr[irr_idx] = 1'b0;
            state_d.isr[irr_idx] = 1'b1;
        end
        if (req_valid) begin
            state_d.irr[req_vector] = 1'b1;
            state_d.tmr[req_vector] = (trig_e'(req_level) == TRIG_LEVEL);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.irr <= '0;
            state_q.isr <= '0;
            state_q.tmr <= '0;
            state_q.tpr <= '0;
            state_q.svr <= SVR_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // R1: the chosen request bit is really set
    p_found_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irr_found |-> state_q.irr[irr_idx]);

    // R2: priority never below task priority nor below in-service class
    p_ppr_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ppr_out >= state_q.tpr);
    p_ppr_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        isr_found |-> ppr_out[VEC_W-1:VEC_W-PRI_W] >= isr_idx[VEC_W-1:VEC_W-PRI_W]);

    // R3: a disabled core never signals
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.svr[VEC_W] |-> !irq_pending);

    // R4: trigger mode captured with the request
    p_trig_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> state_q.tmr[$past(req_vector)] == $past(req_level));

    // R5: spurious acknowledge leaves vectors alone
    p_spur_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_spurious && !req_valid && !eoi_strobe) |=>
        ($stable(state_q.irr) && $stable(state_q.isr)));

    // R6: accepted vector lands in service
    p_ack_to_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_spurious) |=> state_q.isr[$past(ack_vector)]);

    // R7: retired vector leaves service
    p_eoi_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_done && !(ack_take && ack_vector == eoi_vector)) |=>
        !state_q.isr[$past(eoi_vector)]);

    // R9: no vector while disabled
    p_idle_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_strobe && !state_q.svr[VEC_W]) |-> !ack_valid);
endmodule

// File: tb/lapic_prio_core_tb.sv
`timescale 1ns/1ps
module lapic_prio_core_tb_top;
    localparam real CLK_P = 4.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 0, req_level = 0, tpr_wr = 0, svr_wr = 0;
    logic       ack_strobe = 0, eoi_strobe = 0;
    logic [7:0] req_vector = 0, tpr_wdata = 0;
    logic [8:0] svr_wdata = 0;
    logic       irq_pending, ack_valid, ack_spurious, eoi_done, eoi_level;
    logic [7:0] ack_vector, eoi_vector, ppr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [255:0] m_irr, m_isr, m_tmr;
    logic [7:0]   m_tpr;
    logic [8:0]   m_svr;

    always #(CLK_P/2) clk = ~clk;

    lapic_prio_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .svr_wr(svr_wr), .svr_wdata(svr_wdata),
        .ack_strobe(ack_strobe), .eoi_strobe(eoi_strobe),
        .irq_pending(irq_pending), .ack_valid(ack_valid),
        .ack_spurious(ack_spurious), .ack_vector(ack_vector),
        .eoi_done(eoi_done), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .ppr_out(ppr_out)
    );

    function automatic int top_bit(logic [255:0] v);
        int r = -1;
        for (int i = 0; i < 256; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind: 0 idle, 1 request, 2 task priority, 3 spurious reg, 4 ack, 5 eoi
    task automatic apply(int kind, int a, int b);
        int ih, sh, isv, ppr, pend, ev, sp, av;
        @(negedge clk);
        req_valid = 0; tpr_wr = 0; svr_wr = 0; ack_strobe = 0; eoi_strobe = 0;
        case (kind)
            1: begin req_valid = 1; req_vector = 8'(a); req_level = b[0]; end
            2: begin tpr_wr = 1; tpr_wdata = 8'(a); end
            3: begin svr_wr = 1; svr_wdata = 9'(a); end
            4: ack_strobe = 1;
            5: eoi_strobe = 1;
            default: ;
        endcase
        #1;
        ih  = top_bit(m_irr);
        sh  = top_bit(m_isr);
        isv = (sh < 0) ? 0 : sh;
        ppr = ((m_tpr >> 4) >= (isv >> 4)) ? int'(m_tpr) : ((isv >> 4) << 4);
        pend = (m_svr[8] && ih >= 0 && (ppr == 0 || (ih >> 4) > (ppr >> 4))) ? 1 : 0;
        chk("R3 pending", int'(irq_pending), pend);
        chk("R2 processor priority", int'(ppr_out), ppr);
        if (kind == 4) begin
            ev = (m_svr[8] && ih >= 0) ? 1 : 0;
            chk("R9 ack_valid", int'(ack_valid), ev);
            if (ev == 1) begin
                sp = (m_tpr != 0 && ih <= int'(m_tpr)) ? 1 : 0;
                av = sp ? int'(m_svr[7:0]) : ih;
                chk("R5 ack_spurious", int'(ack_spurious), sp);
                chk(sp ? "R5 spurious vector" : "R1 R6 ack vector", int'(ack_vector), av);
                if (sp == 0) begin
                    m_irr[ih] = 1'b0;
                    m_isr[ih] = 1'b1;
                end
            end
        end
        if (kind == 5) begin
            chk("R7 eoi_done", int'(eoi_done), (sh >= 0) ? 1 : 0);
            if (sh >= 0) begin
                chk("R7 eoi_vector", int'(eoi_vector), sh);
                chk("R4 eoi_level", int'(eoi_level), int'(m_tmr[sh]));
                m_isr[sh] = 1'b0;
            end
        end
        if (kind == 1) begin m_irr[a] = 1'b1; m_tmr[a] = b[0]; end
        if (kind == 2) m_tpr = 8'(a);
        if (kind == 3) m_svr = 9'(a);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0; m_svr = 9'h0FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset pending", int'(irq_pending), 0);
        chk("R8 reset ppr", int'(ppr_out), 0);

        // disabled core: request is not signalled, ack is invalid
        apply(1, 8'h40, 0);
        apply(0, 0, 0);
        apply(4, 0, 0);                 // R9
        chk("R9 request kept while disabled", int'(irq_pending), 0);
        apply(3, 9'h1A5, 0);            // R10 enable, spurious A5
        apply(0, 0, 0);
        chk("R10 enable stored", int'(irq_pending), 1);
        apply(4, 0, 0);                 // R6 takes 0x40
        apply(1, 8'h35, 0);
        apply(1, 8'h45, 0);             // same class: masked
        apply(0, 0, 0);
        apply(1, 8'h52, 1);             // level
        apply(2, 8'h60, 0);             // R10 task priority
        apply(0, 0, 0);
        chk("R10 tpr stored", int'(ppr_out), 8'h60);
        apply(4, 0, 0);                 // R5 spurious A5
        chk("R5 spurious vector explicit", int'(ack_vector), 8'hA5);
        apply(2, 8'h00, 0);
        apply(4, 0, 0);                 // 0x52
        apply(4, 0, 0);                 // 0x45
        apply(5, 0, 0);                 // retire 0x52 level
        apply(5, 0, 0);
        apply(5, 0, 0);
        apply(5, 0, 0);                 // none in service
        apply(4, 0, 0);
        apply(5, 0, 0);
        apply(5, 0, 0);

        for (int n = 0; n < 6000; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 35)      apply(1, $urandom_range(0, 255), $urandom_range(0, 1));
            else if (r < 55) apply(4, 0, 0);
            else if (r < 77) apply(5, 0, 0);
            else if (r < 87) apply(2, ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, 255), 0);
            else if (r < 92) apply(3, {($urandom_range(0, 9) != 0), 8'($urandom_range(0, 255))}, 0);
            else             apply(0, 0, 0);
        end
        apply(0, 0, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule